// File: doc/BRIEF.md
# Two-Level Paged Address Translator

This block turns 32-bit virtual addresses into physical addresses for 4 KB pages. A request first meets a small, fully associative buffer of recent translations, which is searched on all entries at once by the 20-bit page number. When the page is present there, the physical address comes back in the next cycle without any memory traffic.

On a buffer miss, the block walks a two-level page table kept in ordinary memory. It uses a simple port on which a request is a one-cycle pulse and a response arrives some cycles later. The top ten address bits pick a word in the outer table. That word gives the base of an inner table, and the next ten bits pick the frame word within it. A successful walk writes its result into the buffer, replacing entries in turn. Before any lookup, the page number is compared with a configured page limit. A page out of range, or a table word without its valid bit, ends the request with a fault.

Only one translation is in flight at a time. A flush input empties the buffer in one cycle.

Top module: `vat_xlate`

## Requirements
- R1: After reset, `idle` is 1, `resp_done` is 0 and `mem_req_valid` is 0.
- R2: A table word carries its valid flag in bit 0 and a 20-bit base or frame number in bits 31:12. The outer read goes to `cfg_table_base + 4*va[31:22]`. The inner read goes to `{outer[31:12], 12'h000} + 4*va[21:12]`.
- R3: A successful translation returns `resp_paddr = {frame, va[11:0]}` with `resp_fault` = 0.
- R4: A buffer miss issues exactly two one-cycle memory requests, outer first and inner second. `resp_done` rises in the cycle after the second response and lasts one cycle.
- R5: A buffer hit raises `resp_done` in the cycle after the request is accepted and issues no memory request.
- R6: When `{1'b0, va[31:12]} >= cfg_page_limit`, the block faults in the cycle after acceptance with no memory request. This check wins over a buffer hit.
- R7: An invalid outer word faults after one read, and an invalid inner word faults after two. A fault reports `resp_paddr` = 0.
- R8: A faulting walk never fills the buffer, so the same address walks again.
- R9: The buffer holds 8 pages, and each successful walk replaces entries in round-robin order. After 9 distinct fills, the oldest page misses and a younger one still hits.
- R10: A one-cycle `flush` pulse invalidates every buffer entry, so the next request for any previously held page walks.
- R11: A request is accepted only while `idle` is 1. A `req_valid` held while busy gives no extra `resp_done` and no extra memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all buffered translations |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| idle | output | 1 | Block can accept a request this cycle |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_fault | output | 1 | Completion is a fault |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| mem_req_valid | output | 1 | One-cycle table read request |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 32 | Table word read |
| cfg_table_base | input | 32 | Physical base of the outer table |
| cfg_page_limit | input | 21 | Page numbers at or above this value fault |

## Verification
A wrong internal state can show at the ports in several ways:
- A corrupted buffer tag or frame shows as a wrong `resp_paddr`, or as a memory read count of 0 where 2 were due (or 2 where 0 were due), on the very next request for that page.
- A replacement pointer that steps wrongly only shows after the eighth fill, when the wrong page is evicted.
- A walk state that slips shows as a `resp_done` one or more cycles early or late, or as a third memory request.

The bench keeps its own buffer image and page-table memory. For each request it predicts the read addresses, the read count, the latency in cycles and the result.

// File: rtl/vat_pkg.sv
package vat_pkg;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int OFF_W = 12;
    localparam int IDX_W = 10;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;
    localparam int LIM_W = VPN_W + 1;

    typedef enum logic [2:0] {
        W_IDLE,
        W_OUT_REQ,
        W_OUT_WAIT,
        W_IN_REQ,
        W_IN_WAIT
    } walk_state_t;

    typedef struct packed {
        logic            done;
        logic            fault;
        logic [PA_W-1:0] paddr;
    } xlate_rsp_t;

    function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
        return va[VA_W-1:OFF_W];
    endfunction

    function automatic logic [IDX_W-1:0] outer_idx(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] inner_idx(input logic [VA_W-1:0] va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic logic pte_valid(input logic [PA_W-1:0] w);
        return w[0];
    endfunction

    function automatic logic [PFN_W-1:0] pte_base(input logic [PA_W-1:0] w);
        return w[PA_W-1:OFF_W];
    endfunction

    function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] tbl,
                                                    input logic [IDX_W-1:0] idx);
        return tbl + {{(PA_W-IDX_W-2){1'b0}}, idx, 2'b00};
    endfunction
endpackage

// File: rtl/vat_tlb.sv
module vat_tlb #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 20,
    parameter int DATA_W  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic [DATA_W-1:0] look_data,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] match;
    logic [TAG_W-1:0]   tags  [ENTRIES];
    logic [DATA_W-1:0]  datas [ENTRIES];
    logic [PTR_W-1:0]   ptr;
    logic               do_fill;

    assign do_fill = fill_en && !flush;

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
        assign match[gi] = vld[gi] && (tags[gi] == look_tag);

        always_ff @(posedge clk) begin
            if (rst) begin
                tags[gi]  <= '0;
                datas[gi] <= '0;
            end else if (do_fill && (ptr == PTR_W'(gi))) begin
                tags[gi]  <= fill_tag;
                datas[gi] <= fill_data;
            end
        end
    end

    always_comb begin
        look_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) look_data = look_data | datas[i];
        end
    end

    assign hit = |match;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            ptr <= '0;
        end else if (flush) begin
            vld <= '0;
        end else if (fill_en) begin
            vld[ptr] <= 1'b1;
            ptr      <= (ptr == PTR_W'(ENTRIES-1)) ? '0 : ptr + 1'b1;
        end
    end

    AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R9

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld == '0)); // R10
endmodule

// File: rtl/vat_walk.sv
module vat_walk
    import vat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  cfg_table_base,
    input  logic [LIM_W-1:0] cfg_page_limit,
    input  logic             tlb_hit,
    input  logic [PFN_W-1:0] tlb_frame,
    input  logic             mem_rsp_valid,
    input  logic [PA_W-1:0]  mem_rsp_data,
    output logic             idle,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_addr,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_tag,
    output logic [PFN_W-1:0] fill_frame,
    output xlate_rsp_t       rsp
);
    walk_state_t      st;
    logic [VA_W-1:0]  va_q;
    logic [PFN_W-1:0] inner_base;
    logic             accept;
    logic             in_range;
    logic             rsp_ok;

    assign accept   = req_valid && (st == W_IDLE);
    assign in_range = {1'b0, vpn_of(req_vaddr)} < cfg_page_limit;
    assign rsp_ok   = pte_valid(mem_rsp_data);
    assign idle     = (st == W_IDLE);

    assign mem_req_valid = (st == W_OUT_REQ) || (st == W_IN_REQ);
    assign mem_req_addr  = (st == W_OUT_REQ)
        ? entry_addr(cfg_table_base, outer_idx(va_q))
        : entry_addr({inner_base, {OFF_W{1'b0}}}, inner_idx(va_q));

    assign fill_en    = (st == W_IN_WAIT) && mem_rsp_valid && rsp_ok;
    assign fill_tag   = vpn_of(va_q);
    assign fill_frame = pte_base(mem_rsp_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= W_IDLE;
            va_q       <= '0;
            inner_base <= '0;
            rsp        <= '0;
        end else begin
            rsp.done  <= 1'b0;
            rsp.fault <= 1'b0;
            unique case (st)
                W_IDLE: begin
                    if (accept) begin
                        va_q <= req_vaddr;
                        if (!in_range) begin
                            rsp.done  <= 1'b1;
                            rsp.fault <= 1'b1;
                            rsp.paddr <= '0;
                        end else if (tlb_hit) begin
                            rsp.done  <= 1'b1;
                            rsp.paddr <= {tlb_frame, req_vaddr[OFF_W-1:0]};
                        end else begin
                            st <= W_OUT_REQ;
                        end
                    end
                end
                W_OUT_REQ: st <= W_OUT_WAIT;
                W_OUT_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!rsp_ok) begin
                            st        <= W_IDLE;
                            rsp.done  <= 1'b1;
                            rsp.fault <= 1'b1;
                            rsp.paddr <= '0;
                        end else begin
                            inner_base <= pte_base(mem_rsp_data);
                            st         <= W_IN_REQ;
                        end
                    end
                end
                W_IN_REQ: st <= W_IN_WAIT;
                W_IN_WAIT: begin
                    if (mem_rsp_valid) begin
                        st       <= W_IDLE;
                        rsp.done <= 1'b1;
                        if (!rsp_ok) begin
                            rsp.fault <= 1'b1;
                            rsp.paddr <= '0;
                        end else begin
                            rsp.paddr <= {pte_base(mem_rsp_data), va_q[OFF_W-1:0]};
                        end
                    end
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    AST_LIMIT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (accept && !in_range) |=> (rsp.done && rsp.fault && !mem_req_valid)); // R6

    AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (accept && in_range && tlb_hit) |=> (rsp.done && !rsp.fault && !mem_req_valid)); // R5

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        (rsp.done && !rsp.fault) |-> (rsp.paddr[OFF_W-1:0] == va_q[OFF_W-1:0])); // R3

    AST_FILL_ONLY_GOOD: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (rsp.done && !rsp.fault)); // R8

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp.fault |-> (rsp.done && (rsp.paddr == '0))); // R7

    AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (st == W_OUT_REQ) |=> !rsp.done); // R11
endmodule

// File: rtl/vat_xlate.sv
module vat_xlate #(
    parameter int TLB_ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    output logic        idle,
    output logic        resp_done,
    output logic        resp_fault,
    output logic [31:0] resp_paddr,
    output logic        mem_req_valid,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    input  logic [31:0] cfg_table_base,
    input  logic [20:0] cfg_page_limit
);
    import vat_pkg::*;

    logic             tlb_hit;
    logic [PFN_W-1:0] tlb_frame;
    logic             fill_en;
    logic [VPN_W-1:0] fill_tag;
    logic [PFN_W-1:0] fill_frame;
    xlate_rsp_t       rsp;

    vat_tlb #(
        .ENTRIES (TLB_ENTRIES),
        .TAG_W   (VPN_W),
        .DATA_W  (PFN_W)
    ) u_tlb (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .look_tag  (vpn_of(req_vaddr)),
        .hit       (tlb_hit),
        .look_data (tlb_frame),
        .fill_en   (fill_en),
        .fill_tag  (fill_tag),
        .fill_data (fill_frame)
    );

    vat_walk u_walk (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_vaddr      (req_vaddr),
        .cfg_table_base (cfg_table_base),
        .cfg_page_limit (cfg_page_limit),
        .tlb_hit        (tlb_hit),
        .tlb_frame      (tlb_frame),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data),
        .idle           (idle),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .fill_en        (fill_en),
        .fill_tag       (fill_tag),
        .fill_frame     (fill_frame),
        .rsp            (rsp)
    );

    assign resp_done  = rsp.done;
    assign resp_fault = rsp.fault;
    assign resp_paddr = rsp.paddr;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!resp_done && !mem_req_valid)); // R1

    AST_DONE_PULSE_AFTER_WALK: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !idle) |=> !resp_done); // R4
endmodule

// File: tb/sim_vat_xlate.sv
module sim_vat_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        idle, resp_done, resp_fault, mem_req_valid;
    logic [31:0] resp_paddr, mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [31:0] cfg_table_base = 32'h0010_0000;
    logic [20:0] cfg_page_limit = 21'h10_0000;

    always #10 clk = ~clk;

    vat_xlate u0 (
        .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .idle(idle), .resp_done(resp_done), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .cfg_table_base(cfg_table_base), .cfg_page_limit(cfg_page_limit)
    );

    int compared = 0;
    int mismatched = 0;
    logic [31:0] mem [logic [31:0]];
    int lat = 1;
    int cnt = 0;
    int nreads = 0;
    logic [31:0] pend = '0;
    logic [31:0] rd_log [$];

    // model translation buffer
    logic [19:0] mt [8];
    logic [19:0] mf [8];
    bit          mv [8];
    int          mp = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] mkva(input int o, input int i, input int off);
        return {o[9:0], i[9:0], off[11:0]};
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // memory responder
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(pend);
            end
        end
        if (!rst && mem_req_valid) begin
            pend = mem_req_addr;
            cnt  = lat;
            nreads++;
            rd_log.push_back(mem_req_addr);
        end
    end

    task automatic run(input logic [31:0] va, input string tag, input bit poke = 0,
                       input logic [31:0] pva = 32'h0);
        logic [19:0] vpn = va[31:12];
        bit          ef = 0;
        logic [31:0] epa = '0;
        int          er = 0;
        int          el = 1;
        logic [31:0] ea [$];
        int          hitidx = -1;
        int          r0;
        int          n;
        if ({1'b0, vpn} >= cfg_page_limit) begin
            ef = 1;
        end else begin
            for (int i = 0; i < 8; i++) if (mv[i] && mt[i] == vpn) hitidx = i;
            if (hitidx >= 0) begin
                epa = {mf[hitidx], va[11:0]};
            end else begin
                logic [31:0] oa;
                logic [31:0] ow;
                oa = cfg_table_base + {20'd0, va[31:22], 2'b00};
                ow = rd(oa);
                ea.push_back(oa);
                er = 1;
                if (!ow[0]) begin
                    ef = 1;
                    el = lat + 2;
                end else begin
                    logic [31:0] ia;
                    logic [31:0] iw;
                    ia = {ow[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
                    iw = rd(ia);
                    ea.push_back(ia);
                    er = 2;
                    el = 2 * lat + 3;
                    if (!iw[0]) ef = 1;
                    else begin
                        epa = {iw[31:12], va[11:0]};
                        mt[mp] = vpn; mf[mp] = iw[31:12]; mv[mp] = 1;
                        mp = (mp + 1) % 8;
                    end
                end
            end
        end
        rd_log.delete();
        r0 = nreads;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            req_valid = poke && (n <= 2);
            if (poke) req_vaddr = pva;
        end while (!resp_done && n < 60);
        req_valid = 1'b0;
        chk({tag, " done seen"}, 32'(resp_done), 32'd1);
        chk({tag, " fault"}, 32'(resp_fault), 32'(ef));
        chk({tag, " paddr"}, resp_paddr, epa);
        chk({tag, " read count"}, 32'(nreads - r0), 32'(er));
        chk({tag, " latency"}, 32'(n), 32'(el));
        for (int i = 0; i < er; i++)
            chk({tag, " R2 read address"}, (rd_log.size() > i) ? rd_log[i] : 32'hxxxx_xxxx, ea[i]);
        @(negedge clk);
        chk({tag, " R4 done one cycle"}, 32'(resp_done), 32'd0);
        if (poke) begin
            int extra = 0;
            int rb = nreads;
            repeat (6) begin
                @(negedge clk);
                if (resp_done) extra++;
            end
            chk({tag, " R11 no extra done"}, 32'(extra), 32'd0);
            chk({tag, " R11 no extra read"}, 32'(nreads - rb), 32'd0);
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        for (int i = 0; i < 8; i++) mv[i] = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog R1..all actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin mt[i] = '0; mf[i] = '0; mv[i] = 0; end
        // outer table: index 1 and 2 valid, 3 left invalid
        mem[32'h0010_0004] = 32'h0020_0001;
        mem[32'h0010_0008] = 32'h0030_0001;
        for (int i = 0; i < 16; i++)
            mem[32'h0020_0000 + 32'(i * 4)] = {20'h40000 + 20'(i * 17), 12'h001};
        for (int i = 0; i < 4; i++)
            mem[32'h0030_0000 + 32'(i * 4)] = {20'h50000 + 20'(i), 12'h001};

        repeat (3) @(negedge clk);
        chk("R1 idle", 32'(idle), 32'd1);
        chk("R1 done", 32'(resp_done), 32'd0);
        chk("R1 mem req", 32'(mem_req_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after release", 32'(idle), 32'd1);

        run(mkva(1, 0, 12'h123), "R2 R3 R4 first walk");
        run(mkva(1, 0, 12'habc), "R5 hit");
        run(mkva(3, 0, 12'h010), "R7 outer invalid");
        run(mkva(3, 0, 12'h010), "R8 outer fault not kept");
        run(mkva(1, 20, 12'h000), "R7 inner invalid");
        run(mkva(1, 20, 12'h000), "R8 inner fault not kept");
        lat = 3;
        run(mkva(2, 1, 12'h7ff), "R4 slow memory walk");
        run(mkva(2, 1, 12'h001), "R5 hit after slow walk");
        lat = 1;

        cfg_page_limit = 21'h401;
        run(mkva(1, 1, 12'h000), "R6 page at limit");
        cfg_page_limit = 21'h400;
        run(mkva(1, 0, 12'h055), "R6 limit beats hit");
        cfg_page_limit = 21'h10_0000;

        do_flush();
        run(mkva(1, 0, 12'h200), "R10 walk after flush");
        run(mkva(2, 1, 12'h200), "R10 second page walks after flush");
        for (int i = 1; i <= 7; i++) run(mkva(1, i, 12'h000), "R9 fill");
        run(mkva(1, 2, 12'h004), "R9 younger entry kept");
        run(mkva(1, 0, 12'h008), "R9 oldest entry evicted");

        run(mkva(2, 2, 12'h044), "R11 busy request ignored", 1, mkva(2, 3, 12'h000));
        run(mkva(2, 3, 12'h000), "R11 poked page not cached");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule